// File: doc/BRIEF.md
# Two-Tier Receive Buffer Allocator

This block hands out receive buffer addresses to a set of receive queues. Each queue owns a small private pool of buffer addresses that the host posts in advance, and all queues share one larger reserve pool. When a packet arrives on a queue, the block first takes a buffer from that queue's private pool. Only when that pool is empty does it take one from the shared reserve. If both are empty, it reports a drop. Every grant carries a flag that says which pool the buffer came from. The host needs this flag because reserve buffers go back through a return path that synchronizes across queues.

The host refills the pools through two ports: one port for the private pools, with a queue index, and one port for the reserve. Each pool is a first-in first-out store of buffer base addresses. Buffers are aligned to `BUF_BYTES`, so only the bits above the in-buffer offset are stored. The block reports the occupancy of every pool and a drop count per queue. A reserve-low flag compares the reserve occupancy with a threshold that software programs.

The default sizes are 8 queues, 16 private entries per queue and 64 reserve entries. These keep storage small for elaboration; a deployment raises them through the parameters.

Top module: `rxa_alloc`

## Requirements
- R1: A request for a queue whose private occupancy is nonzero is granted from that queue's private pool, with `gnt_from_reserve` = 0 and `gnt_drop` = 0.
- R2: A request for a queue whose private occupancy is zero is granted from the reserve when the reserve is nonempty, with `gnt_from_reserve` = 1.
- R3: When both the queue's private pool and the reserve are empty, the request gets `gnt_drop` = 1, `gnt_from_reserve` = 0 and `gnt_addr` = 0. That queue's field of `drop_count` (bits q*DROP_W upward) increments by one, modulo 2^DROP_W.
- R4: For a request accepted on clock edge t, `gnt_valid` is high in the cycle after edge t, and `gnt_queue` echoes the request's queue. With no request on an edge, `gnt_valid` is low in the cycle after it.
- R5: Each pool returns addresses in the order in which they were refilled.
- R6: A request or a refill for one queue leaves every other queue's private pool and occupancy unchanged.
- R7: A refill and a request that hit the same pool on the same edge are both carried out, and that pool's occupancy is unchanged. The pool choice uses the occupancy from before the edge, so a refill into an empty pool cannot serve a request on that same edge. A refill into a full pool is accepted when that pool is popped on the same edge.
- R8: A refill into a full pool that is not popped on the same edge is rejected, and the pool contents stay unchanged. The rejection shows as a one-cycle pulse on `ded_fill_err` or `res_fill_err` in the cycle after that edge.
- R9: `ded_count` (field q at bits q*DCW upward) and `res_count` give the pool occupancies after each edge.
- R10: `res_low` is 1 exactly when `res_count` is less than `res_low_thresh`.
- R11: The low log2(BUF_BYTES) bits of a refill address are ignored, and every granted address has those bits at zero.
- R12: After reset, all pools are empty, all counts and drop counters are zero, and no grant, drop or error is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Buffer request for a received packet |
| req_queue | input | QW | Queue index of the request |
| ded_fill_valid | input | 1 | Refill of a private pool |
| ded_fill_queue | input | QW | Queue whose private pool is refilled |
| ded_fill_addr | input | ADDR_W | Buffer address for the private refill |
| res_fill_valid | input | 1 | Refill of the reserve |
| res_fill_addr | input | ADDR_W | Buffer address for the reserve refill |
| res_low_thresh | input | RCW | Threshold for the reserve-low flag |
| gnt_valid | output | 1 | Grant response, one cycle after the request |
| gnt_queue | output | QW | Queue of the grant |
| gnt_addr | output | ADDR_W | Granted buffer address, 0 on a drop |
| gnt_from_reserve | output | 1 | 1 when the buffer came from the reserve |
| gnt_drop | output | 1 | No buffer was available |
| ded_fill_err | output | 1 | A private refill hit a full pool |
| res_fill_err | output | 1 | A reserve refill hit a full pool |
| ded_count | output | NUM_Q*DCW | Private occupancy of each queue |
| res_count | output | RCW | Reserve occupancy |
| res_low | output | 1 | Reserve occupancy below the threshold |
| drop_count | output | NUM_Q*DROP_W | Drop count of each queue |

## Verification
The bench drives a request on a queue whose private pool has just run dry while the reserve still holds entries. A design that checks the reserve first, or picks a pool from the wrong queue, shows a wrong source flag or a wrong address at once. It lands a refill and a request on the same pool in the same cycle, both when the pool is empty and when it is full. A design that bypasses the refill into the grant, or rejects the refill into a pool that is being popped, shows a wrong address, a false error pulse or an occupancy off by one. It overfills both pools, drains everything until requests drop, and moves the reserve threshold around. This exposes lost entries, overwritten FIFO slots, drop counters on the wrong queue and an off-by-one comparison in the reserve-low flag.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
   typedef enum logic {
      SRC_PRIVATE = 1'b0,
      SRC_SHARED  = 1'b1
   } rxa_src_e;

   function automatic int occ_w(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/rxa_fifo.sv
module rxa_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 19,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = rxa_pkg::occ_w(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          push_rej
);
   logic [W-1:0]  slots [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic          pop_ok, push_ok;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   // a full pool still takes a refill when it is popped on the same edge
   assign empty    = (count == '0);
   assign pop_ok   = pop && !empty;
   assign push_ok  = push && ((count != CW'(DEPTH)) || pop_ok);
   assign push_rej = push && !push_ok;
   assign dout     = slots[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (pop_ok)  rd_ptr <= step(rd_ptr);
         if (push_ok) wr_ptr <= step(wr_ptr);
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) slots[wr_ptr] <= din;
   end
endmodule

// File: rtl/rxa_pick.sv
module rxa_pick (
   input  logic req_valid,
   input  logic ded_avail,
   input  logic res_avail,
   output logic take_ded,
   output logic take_res,
   output logic drop
);
   // private pool first, shared reserve only as a fallback
   assign take_ded = req_valid && ded_avail;
   assign take_res = req_valid && !ded_avail && res_avail;
   assign drop     = req_valid && !ded_avail && !res_avail;
endmodule

// File: rtl/rxa_alloc.sv
module rxa_alloc #(
   parameter int NUM_Q     = 8,
   parameter int DED_DEPTH = 16,
   parameter int RES_DEPTH = 64,
   parameter int ADDR_W    = 32,
   parameter int BUF_BYTES = 8192,
   parameter int DROP_W    = 16,
   localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
   localparam int DCW   = rxa_pkg::occ_w(DED_DEPTH),
   localparam int RCW   = rxa_pkg::occ_w(RES_DEPTH),
   localparam int OFS_W = $clog2(BUF_BYTES),
   localparam int TAG_W = ADDR_W - OFS_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [QW-1:0]           req_queue,
   input  logic                    ded_fill_valid,
   input  logic [QW-1:0]           ded_fill_queue,
   input  logic [ADDR_W-1:0]       ded_fill_addr,
   input  logic                    res_fill_valid,
   input  logic [ADDR_W-1:0]       res_fill_addr,
   input  logic [RCW-1:0]          res_low_thresh,
   output logic                    gnt_valid,
   output logic [QW-1:0]           gnt_queue,
   output logic [ADDR_W-1:0]       gnt_addr,
   output logic                    gnt_from_reserve,
   output logic                    gnt_drop,
   output logic                    ded_fill_err,
   output logic                    res_fill_err,
   output logic [NUM_Q*DCW-1:0]    ded_count,
   output logic [RCW-1:0]          res_count,
   output logic                    res_low,
   output logic [NUM_Q*DROP_W-1:0] drop_count
);
   import rxa_pkg::*;

   // elaboration-time parameter checks
   if (NUM_Q < 1 || (NUM_Q & (NUM_Q - 1)) != 0) begin : g_bad_nq
      $error("rxa_alloc: NUM_Q must be a power of two");
   end
   if (BUF_BYTES < 2 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("rxa_alloc: BUF_BYTES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_aw
      $error("rxa_alloc: ADDR_W must exceed log2(BUF_BYTES)");
   end
   if (DED_DEPTH < 1 || RES_DEPTH < 1 || DROP_W < 1) begin : g_bad_depth
      $error("rxa_alloc: depths and counter width must be positive");
   end

   logic [TAG_W-1:0] ded_dout  [NUM_Q];
   logic [DCW-1:0]   ded_cnt   [NUM_Q];
   logic [DROP_W-1:0] drops    [NUM_Q];
   logic [NUM_Q-1:0] ded_empty, ded_pop, ded_push, ded_rej;
   logic [TAG_W-1:0] res_dout;
   logic             res_empty, res_rej;
   logic             take_ded, take_res, drop_now;
   rxa_src_e         src;

   rxa_pick u_pick (
      .req_valid (req_valid),
      .ded_avail (!ded_empty[req_queue]),
      .res_avail (!res_empty),
      .take_ded  (take_ded),
      .take_res  (take_res),
      .drop      (drop_now)
   );

   for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
      assign ded_pop[q]  = take_ded && (req_queue == QW'(q));
      assign ded_push[q] = ded_fill_valid && (ded_fill_queue == QW'(q));

      rxa_fifo #(.DEPTH(DED_DEPTH), .W(TAG_W)) u_ded (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (ded_push[q]),
         .pop      (ded_pop[q]),
         .din      (ded_fill_addr[ADDR_W-1:OFS_W]),
         .dout     (ded_dout[q]),
         .count    (ded_cnt[q]),
         .empty    (ded_empty[q]),
         .push_rej (ded_rej[q])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)                                   drops[q] <= '0;
         else if (drop_now && req_queue == QW'(q))     drops[q] <= drops[q] + 1'b1;
      end

      assign ded_count[q*DCW +: DCW]        = ded_cnt[q];
      assign drop_count[q*DROP_W +: DROP_W] = drops[q];
   end

   rxa_fifo #(.DEPTH(RES_DEPTH), .W(TAG_W)) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (res_fill_valid),
      .pop      (take_res),
      .din      (res_fill_addr[ADDR_W-1:OFS_W]),
      .dout     (res_dout),
      .count    (res_count),
      .empty    (res_empty),
      .push_rej (res_rej)
   );

   assign src     = take_res ? SRC_SHARED : SRC_PRIVATE;
   assign res_low = (res_count < res_low_thresh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_valid        <= 1'b0;
         gnt_queue        <= '0;
         gnt_addr         <= '0;
         gnt_from_reserve <= 1'b0;
         gnt_drop         <= 1'b0;
         ded_fill_err     <= 1'b0;
         res_fill_err     <= 1'b0;
      end else begin
         gnt_valid        <= req_valid;
         gnt_queue        <= req_queue;
         gnt_from_reserve <= (src == SRC_SHARED);
         gnt_drop         <= drop_now;
         if (take_ded)      gnt_addr <= {ded_dout[req_queue], OFS_W'(0)};
         else if (take_res) gnt_addr <= {res_dout, OFS_W'(0)};
         else               gnt_addr <= '0;
         ded_fill_err     <= |ded_rej;
         res_fill_err     <= res_rej;
      end
   end
endmodule

// File: rtl/rxa_alloc_chk.sv
module rxa_alloc_chk #(
   parameter int NUM_Q     = 8,
   parameter int DED_DEPTH = 16,
   parameter int RES_DEPTH = 64,
   parameter int ADDR_W    = 32,
   parameter int BUF_BYTES = 8192,
   localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
   localparam int DCW   = rxa_pkg::occ_w(DED_DEPTH),
   localparam int RCW   = rxa_pkg::occ_w(RES_DEPTH),
   localparam int OFS_W = $clog2(BUF_BYTES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [QW-1:0]        req_queue,
   input logic                 res_fill_valid,
   input logic                 gnt_valid,
   input logic [QW-1:0]        gnt_queue,
   input logic [ADDR_W-1:0]    gnt_addr,
   input logic                 gnt_from_reserve,
   input logic                 gnt_drop,
   input logic [NUM_Q*DCW-1:0] ded_count,
   input logic [RCW-1:0]       res_count
);
   logic [DCW-1:0] sel_ded;
   assign sel_ded = ded_count[req_queue*DCW +: DCW];

   AST_GNT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> gnt_valid && gnt_queue == $past(req_queue)); // R4
   AST_GNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !gnt_valid); // R4
   AST_PRIVATE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && sel_ded != '0 |=> !gnt_from_reserve && !gnt_drop); // R1
   AST_RESERVE_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && sel_ded == '0 && res_count != '0 |=> gnt_from_reserve && !gnt_drop); // R2
   AST_DROP_WHEN_DRY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && sel_ded == '0 && res_count == '0 |=> gnt_drop); // R3
   AST_DROP_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_drop |-> gnt_addr == '0 && !gnt_from_reserve); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      res_count <= RCW'(RES_DEPTH)); // R8
   AST_SAME_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      res_fill_valid && req_valid && sel_ded == '0 && res_count != '0
      |=> res_count == $past(res_count)); // R7
   AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> gnt_addr[OFS_W-1:0] == '0); // R11
endmodule

bind rxa_alloc rxa_alloc_chk #(
   .NUM_Q(NUM_Q), .DED_DEPTH(DED_DEPTH), .RES_DEPTH(RES_DEPTH),
   .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_queue(req_queue),
   .res_fill_valid(res_fill_valid), .gnt_valid(gnt_valid), .gnt_queue(gnt_queue),
   .gnt_addr(gnt_addr), .gnt_from_reserve(gnt_from_reserve), .gnt_drop(gnt_drop),
   .ded_count(ded_count), .res_count(res_count)
);

// File: tb/tb_rxa_alloc.sv
`timescale 1ns/1ps
module tb_rxa_alloc;
   localparam int NQ  = 8;
   localparam int DD  = 16;
   localparam int RD  = 64;
   localparam int AW  = 32;
   localparam int BB  = 8192;
   localparam int DW  = 16;
   localparam int QW  = 3;
   localparam int DCW = $clog2(DD + 1);
   localparam int RCW = $clog2(RD + 1);
   localparam int OFS = $clog2(BB);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, ded_fill_valid = 1'b0, res_fill_valid = 1'b0;
   logic [QW-1:0] req_queue = '0, ded_fill_queue = '0;
   logic [AW-1:0] ded_fill_addr = '0, res_fill_addr = '0;
   logic [RCW-1:0] res_low_thresh = '0;
   logic gnt_valid, gnt_from_reserve, gnt_drop, ded_fill_err, res_fill_err, res_low;
   logic [QW-1:0] gnt_queue;
   logic [AW-1:0] gnt_addr;
   logic [NQ*DCW-1:0] ded_count;
   logic [RCW-1:0] res_count;
   logic [NQ*DW-1:0] drop_count;

   always #2 clk = ~clk;  // 250 MHz

   rxa_alloc #(.NUM_Q(NQ), .DED_DEPTH(DD), .RES_DEPTH(RD), .ADDR_W(AW),
               .BUF_BYTES(BB), .DROP_W(DW)) dut (.*);

   // reference model
   logic [AW-1:0] m_ded [NQ][DD];
   int m_drd [NQ], m_dwr [NQ], m_dcnt [NQ], m_drop [NQ];
   logic [AW-1:0] m_res [RD];
   int m_rrd, m_rwr, m_rcnt;
   int checks = 0, errors = 0;
   bit done = 0;

   function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
      return {a[AW-1:OFS], OFS'(0)};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit rv, input int rq, input bit dv, input int dq,
                      input logic [AW-1:0] da, input bit fv, input logic [AW-1:0] fa);
      bit took_d, took_r, e_drop, e_derr, e_rerr, same_d, same_r;
      logic [AW-1:0] e_addr;
      string tag;
      req_valid = rv; req_queue = QW'(rq);
      ded_fill_valid = dv; ded_fill_queue = QW'(dq); ded_fill_addr = da;
      res_fill_valid = fv; res_fill_addr = fa;
      took_d = rv && m_dcnt[rq] > 0;
      took_r = rv && !took_d && m_rcnt > 0;
      e_drop = rv && !took_d && !took_r;
      same_d = took_d && dv && dq == rq;
      same_r = took_r && fv;
      e_addr = '0; e_derr = 0; e_rerr = 0;
      if (took_d) begin
         e_addr = m_ded[rq][m_drd[rq]];
         m_drd[rq] = (m_drd[rq] + 1) % DD; m_dcnt[rq]--;
      end
      if (took_r) begin
         e_addr = m_res[m_rrd]; m_rrd = (m_rrd + 1) % RD; m_rcnt--;
      end
      if (e_drop) m_drop[rq] = (m_drop[rq] + 1) % (1 << DW);
      if (dv) begin
         if (m_dcnt[dq] < DD) begin
            m_ded[dq][m_dwr[dq]] = align(da);
            m_dwr[dq] = (m_dwr[dq] + 1) % DD; m_dcnt[dq]++;
         end else e_derr = 1;
      end
      if (fv) begin
         if (m_rcnt < RD) begin
            m_res[m_rwr] = align(fa); m_rwr = (m_rwr + 1) % RD; m_rcnt++;
         end else e_rerr = 1;
      end
      @(posedge clk);
      @(negedge clk);
      chk("R4 valid", gnt_valid, rv);
      if (rv) begin
         tag = e_drop ? "R3 source" : (took_r ? "R2 source" : "R1 source");
         chk("R4 queue", gnt_queue, rq);
         chk(tag, gnt_from_reserve, took_r);
         chk("R3 drop", gnt_drop, e_drop);
         chk("R5 address", gnt_addr, e_addr);
         chk("R11 align", gnt_addr[OFS-1:0], 0);
      end
      chk("R8 private err", ded_fill_err, e_derr);
      chk("R8 reserve err", res_fill_err, e_rerr);
      for (int q = 0; q < NQ; q++) begin
         if (same_d && q == rq)         chk("R7 private count", ded_count[q*DCW +: DCW], m_dcnt[q]);
         else if ((rv && q == rq) || (dv && q == dq))
                                        chk("R9 private count", ded_count[q*DCW +: DCW], m_dcnt[q]);
         else                           chk("R6 other queue", ded_count[q*DCW +: DCW], m_dcnt[q]);
         chk("R3 drop count", drop_count[q*DW +: DW], m_drop[q]);
      end
      chk(same_r ? "R7 reserve count" : "R9 reserve count", res_count, m_rcnt);
      chk("R10 low flag", res_low, (m_rcnt < int'(res_low_thresh)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17_C0DE));
      for (int q = 0; q < NQ; q++) begin
         m_drd[q] = 0; m_dwr[q] = 0; m_dcnt[q] = 0; m_drop[q] = 0;
      end
      m_rrd = 0; m_rwr = 0; m_rcnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      chk("R12 valid", gnt_valid, 0);
      chk("R12 drop", gnt_drop, 0);
      chk("R12 errs", {ded_fill_err, res_fill_err}, 0);
      chk("R12 private counts", ded_count, 0);
      chk("R12 reserve count", res_count, 0);
      chk("R12 drop counts", drop_count, 0);
      chk("R12 low", res_low, 0);

      // R3: everything empty
      cyc(1, 1, 0, 0, 0, 0, 0);
      // R2: reserve used once the private pool is dry
      cyc(0, 0, 0, 0, 0, 1, 32'h1111_3FFF);
      cyc(0, 0, 0, 0, 0, 1, 32'h2222_4000);
      cyc(1, 1, 0, 0, 0, 0, 0);
      // R8: overfill queue 2
      for (int i = 0; i <= DD; i++) cyc(0, 0, 1, 2, 32'h8000_0000 + i * BB, 0, 0);
      // R7: full pool popped and refilled on one edge
      cyc(1, 2, 1, 2, 32'hABCD_E123, 0, 0);
      // R1 then R2: drain queue 2 past empty
      for (int i = 0; i <= DD; i++) cyc(1, 2, 0, 0, 0, 0, 0);
      // R7: refill into empty pool does not serve the same edge
      cyc(1, 2, 1, 2, 32'h0F0F_0000, 0, 0);
      cyc(1, 2, 0, 0, 0, 0, 0);
      // R8: overfill the reserve; R10 threshold around the fill level
      for (int i = 0; i <= RD; i++) cyc(0, 0, 0, 0, 0, 1, 32'h4000_0000 + i * BB);
      res_low_thresh = RCW'(RD);
      cyc(0, 0, 0, 0, 0, 0, 0);
      cyc(1, 5, 0, 0, 0, 0, 0);
      res_low_thresh = RCW'(RD - 1);
      cyc(0, 0, 0, 0, 0, 0, 0);

      // constrained random phase
      for (int n = 0; n < 6000; n++) begin
         if ($urandom_range(0, 63) == 0) res_low_thresh = RCW'($urandom_range(0, RD));
         cyc($urandom_range(0, 99) < 55, $urandom_range(0, NQ - 1),
             $urandom_range(0, 99) < 45, $urandom_range(0, NQ - 1), $urandom,
             $urandom_range(0, 99) < 12, $urandom);
      end
      // drain to force drops late in the run
      for (int n = 0; n < NQ * DD + RD + 20; n++) cyc(1, n % NQ, 0, 0, 0, 0, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule